// File: doc/BRIEF.md
# Conditional Jump and Loop Evaluator

This block decides, for each branch-class operation handed to it, whether the branch is taken, and for the two counted-loop forms it also produces the stepped loop count together with a write enable for the count register. It holds the processor's status flags (negative, zero, positive, carry). Software-visible flag values can be loaded directly, and a compare operation updates the flags from the true signed order of its two operands, with no overflow error.

A conditional jump selects the flags it tests with a three-bit mask: bit 0 tests "low", bit 1 "equal" and bit 2 "high". The two loop forms step the count first, down by one or up by one, then compare the new count with a limit value. When the branch uses indexed addressing, the target is the word stored at the effective address, so the block raises a request for an indirect target fetch on every taken indexed branch. This includes the subroutine call. Fetching instructions and the memory access itself are done elsewhere.

Results are registered. A branch presented in one cycle produces its outputs in the next cycle, for one cycle.

Top module: `jle_eval`

## Requirements
- R1: While reset is high, and in the first cycle after it, `res_valid`, `taken`, `cnt_we` and `fetch_indirect` are 0, `cnt_out` is 0 and all four flags are 0.
- R2: For class 0 (conditional jump) with a mask other than 7, the jump is taken exactly when some mask bit is set whose flag is also set: mask bit 0 pairs with the N flag (low), bit 1 with Z (equal), bit 2 with P (high). Mask 0 never jumps.
- R3: For class 0 with mask 7, the jump is always taken, whatever the flags hold.
- R4: A compare (`cmp_en`) sets exactly one of N, Z, P. It sets N when `cmp_a` < `cmp_b`, Z when they are equal and P when `cmp_a` > `cmp_b`, both read as signed 32-bit values and ordered by their true difference, so no overflow occurs. The carry flag keeps its value.
- R5: `flag_wr` loads the flags from `flag_in`, where bit 3 is C, bit 2 is P, bit 1 is Z and bit 0 is N. If `cmp_en` is high in the same cycle, the compare wins and `flag_in` is ignored.
- R6: For class 2 (index high), `cnt_out` is `count_in` − 1 (modulo 2^32) with `cnt_we` = 1. The jump is taken exactly when the new count is greater than `limit_in`, both read as signed.
- R7: For class 3 (index low-or-equal), `cnt_out` is `count_in` + 1 (modulo 2^32) with `cnt_we` = 1. The jump is taken exactly when the new count is less than or equal to `limit_in`, both read as signed.
- R8: Class 1 (subroutine jump) is always taken. For classes 0 and 1, `cnt_we` is 0 and `cnt_out` is 0.
- R9: `fetch_indirect` is 1 exactly when the branch is taken and `indexed` was high with it, for every class.
- R10: The results of a branch appear the cycle after `jmp_valid` is high. In every other cycle `res_valid`, `taken`, `cnt_we`, `fetch_indirect` and `cnt_out` are 0. A branch tests the flags as they were before any flag update in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_wr | input | 1 | Load flags from `flag_in` |
| flag_in | input | 4 | Flag values {C, P, Z, N} |
| cmp_en | input | 1 | Compare `cmp_a` with `cmp_b` and update N/Z/P |
| cmp_a | input | 32 | First compare operand (signed) |
| cmp_b | input | 32 | Second compare operand (signed) |
| jmp_valid | input | 1 | A branch is presented this cycle |
| jmp_class | input | 2 | 0 conditional, 1 subroutine, 2 index high, 3 index low-or-equal |
| cond_mask | input | 3 | Condition mask {high, equal, low} |
| count_in | input | 32 | Current count register value |
| limit_in | input | 32 | Limit register value |
| indexed | input | 1 | Branch uses indexed (indirect) addressing |
| res_valid | output | 1 | Results of a branch are on the outputs |
| taken | output | 1 | Branch is taken |
| cnt_out | output | 32 | Stepped count value |
| cnt_we | output | 1 | Write `cnt_out` to the count register |
| fetch_indirect | output | 1 | Fetch the target word from the effective address |
| flags | output | 4 | Current flags {C, P, Z, N} |

## Verification
The bench runs compares on operand pairs whose plain 32-bit difference overflows, such as the most positive value against the most negative. A design that took the sign from a 32-bit subtraction would report the opposite order. Loop steps that wrap the count across the signed boundary are also driven. A design that compared the old count, or compared unsigned, would take the wrong branch. The bench walks all eight masks over each flag pattern, including all-clear flags with mask 7, which exposes a design that treats "always" as the OR of the three tests. It also presents compares and flag loads in the same cycle as a branch, or as each other, to catch wrong priority and branches that test the freshly written flags.

// File: rtl/jle_pkg.sv
package jle_pkg;

    typedef enum logic [1:0] {
        JC_COND   = 2'd0,
        JC_SUB    = 2'd1,
        JC_IDX_HI = 2'd2,
        JC_IDX_LE = 2'd3
    } jclass_e;

    typedef struct packed {
        logic c;
        logic p;
        logic z;
        logic n;
    } flags_t;

    localparam int MASK_W   = 3;
    localparam int MB_LOW   = 0;
    localparam int MB_EQUAL = 1;
    localparam int MB_HIGH  = 2;
    localparam logic [MASK_W-1:0] MASK_ALWAYS = '1;

    function automatic logic cond_hit(input logic [MASK_W-1:0] mask, input flags_t f);
        logic hit;
        if (mask == MASK_ALWAYS) begin
            hit = 1'b1;
        end else begin
            hit = (mask[MB_LOW] & f.n) | (mask[MB_EQUAL] & f.z) | (mask[MB_HIGH] & f.p);
        end
        return hit;
    endfunction

endpackage

// File: rtl/jle_scmp.sv
module jle_scmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt,
    output logic         eq,
    output logic         gt
);
    localparam int XW = W + 1;

    logic [XW-1:0] diff;

    always_comb begin
        diff = {a[W-1], a} - {b[W-1], b};
        lt   = diff[XW-1];
        eq   = (diff == '0);
        gt   = !diff[XW-1] && (diff != '0);
    end
endmodule

// File: rtl/jle_flag_reg.sv
module jle_flag_reg
    import jle_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flag_wr,
    input  flags_t       flag_in,
    input  logic         cmp_en,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    output flags_t       flags_q
);
    logic c_lt, c_eq, c_gt;

    jle_scmp #(.W(W)) u_cmp (
        .a  (cmp_a),
        .b  (cmp_b),
        .lt (c_lt),
        .eq (c_eq),
        .gt (c_gt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (cmp_en) begin
            flags_q.n <= c_lt;
            flags_q.z <= c_eq;
            flags_q.p <= c_gt;
        end else if (flag_wr) begin
            flags_q <= flag_in;
        end
    end
endmodule

// File: rtl/jle_loop_unit.sv
module jle_loop_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] count_in,
    input  logic [W-1:0] limit_in,
    input  logic         step_down,
    output logic [W-1:0] count_next,
    output logic         loop_hit
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic n_lt, n_eq, n_gt;

    always_comb begin
        if (step_down) begin
            count_next = count_in - ONE;
        end else begin
            count_next = count_in + ONE;
        end
    end

    jle_scmp #(.W(W)) u_cmp (
        .a  (count_next),
        .b  (limit_in),
        .lt (n_lt),
        .eq (n_eq),
        .gt (n_gt)
    );

    always_comb begin
        if (step_down) begin
            loop_hit = n_gt;
        end else begin
            loop_hit = n_lt | n_eq;
        end
    end
endmodule

// File: rtl/jle_eval.sv
module jle_eval
    import jle_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flag_wr,
    input  logic [3:0]        flag_in,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              jmp_valid,
    input  logic [1:0]        jmp_class,
    input  logic [2:0]        cond_mask,
    input  logic [DATA_W-1:0] count_in,
    input  logic [DATA_W-1:0] limit_in,
    input  logic              indexed,
    output logic              res_valid,
    output logic              taken,
    output logic [DATA_W-1:0] cnt_out,
    output logic              cnt_we,
    output logic              fetch_indirect,
    output logic [3:0]        flags
);
    flags_t  flags_q;
    jclass_e cls;
    logic [DATA_W-1:0] lp_next;
    logic lp_hit;
    logic take_c, we_c;
    logic [DATA_W-1:0] cnt_c;

    assign cls   = jclass_e'(jmp_class);
    assign flags = flags_q;

    jle_flag_reg #(.W(DATA_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .flag_wr (flag_wr),
        .flag_in (flags_t'(flag_in)),
        .cmp_en  (cmp_en),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .flags_q (flags_q)
    );

    jle_loop_unit #(.W(DATA_W)) u_loop (
        .count_in   (count_in),
        .limit_in   (limit_in),
        .step_down  (cls == JC_IDX_HI),
        .count_next (lp_next),
        .loop_hit   (lp_hit)
    );

    always_comb begin
        take_c = 1'b0;
        we_c   = 1'b0;
        cnt_c  = '0;
        unique case (cls)
            JC_COND: take_c = cond_hit(cond_mask, flags_q);
            JC_SUB:  take_c = 1'b1;
            JC_IDX_HI, JC_IDX_LE: begin
                take_c = lp_hit;
                we_c   = 1'b1;
                cnt_c  = lp_next;
            end
            default: take_c = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !jmp_valid) begin
            res_valid      <= 1'b0;
            taken          <= 1'b0;
            cnt_we         <= 1'b0;
            cnt_out        <= '0;
            fetch_indirect <= 1'b0;
        end else begin
            res_valid      <= 1'b1;
            taken          <= take_c;
            cnt_we         <= we_c;
            cnt_out        <= cnt_c;
            fetch_indirect <= take_c & indexed;
        end
    end
endmodule

// File: rtl/jle_eval_chk.sv
module jle_eval_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              flag_wr,
    input logic [3:0]        flag_in,
    input logic              cmp_en,
    input logic [DATA_W-1:0] cmp_a,
    input logic [DATA_W-1:0] cmp_b,
    input logic              jmp_valid,
    input logic [1:0]        jmp_class,
    input logic [2:0]        cond_mask,
    input logic [DATA_W-1:0] count_in,
    input logic [DATA_W-1:0] limit_in,
    input logic              indexed,
    input logic              res_valid,
    input logic              taken,
    input logic [DATA_W-1:0] cnt_out,
    input logic              cnt_we,
    input logic              fetch_indirect,
    input logic [3:0]        flags
);
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        jmp_valid |=> res_valid);

    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!taken && !cnt_we && !fetch_indirect && cnt_out == '0));

    a_r9_indirect: assert property (@(posedge clk) disable iff (rst)
        fetch_indirect |-> taken);

    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
        cmp_en |=> ($countones(flags[2:0]) == 1));

    a_r4_carry_kept: assert property (@(posedge clk) disable iff (rst)
        cmp_en |=> (flags[3] == $past(flags[3])));

    a_r8_sub: assert property (@(posedge clk) disable iff (rst)
        (jmp_valid && jmp_class == 2'd1) |=> (taken && !cnt_we));

    a_r6_count: assert property (@(posedge clk) disable iff (rst)
        (jmp_valid && jmp_class == 2'd2) |=> (cnt_we && cnt_out == $past(count_in) - 1'b1));

    a_r7_count: assert property (@(posedge clk) disable iff (rst)
        (jmp_valid && jmp_class == 2'd3) |=> (cnt_we && cnt_out == $past(count_in) + 1'b1));

    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && !cmp_en) |=> (flags == $past(flag_in)));
endmodule

bind jle_eval jle_eval_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/jle_eval_test.sv
`timescale 1ns/1ps
module jle_eval_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flag_wr = 0, cmp_en = 0, jmp_valid = 0, indexed = 0;
    logic [3:0]  flag_in = 0;
    logic [31:0] cmp_a = 0, cmp_b = 0, count_in = 0, limit_in = 0;
    logic [1:0]  jmp_class = 0;
    logic [2:0]  cond_mask = 0;
    logic        res_valid, taken, cnt_we, fetch_indirect;
    logic [31:0] cnt_out;
    logic [3:0]  flags;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    // reference model state
    bit          m_valid, m_taken, m_we, m_fetch;
    logic [31:0] m_cnt;
    logic [3:0]  m_flags;
    string       otag, ftag;

    always #2.5 clk = ~clk;

    jle_eval uut (
        .clk(clk), .rst(rst), .flag_wr(flag_wr), .flag_in(flag_in),
        .cmp_en(cmp_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .jmp_valid(jmp_valid), .jmp_class(jmp_class), .cond_mask(cond_mask),
        .count_in(count_in), .limit_in(limit_in), .indexed(indexed),
        .res_valid(res_valid), .taken(taken), .cnt_out(cnt_out),
        .cnt_we(cnt_we), .fetch_indirect(fetch_indirect), .flags(flags)
    );

    always @(posedge clk) begin
        longint sa, sb, nc, lm;
        bit hit;
        if (rst) begin
            m_valid = 0; m_taken = 0; m_we = 0; m_fetch = 0; m_cnt = 0;
            m_flags = 0; otag = "R1"; ftag = "R1";
        end else begin
            m_valid = 0; m_taken = 0; m_we = 0; m_fetch = 0; m_cnt = 0;
            otag = "R10";
            if (jmp_valid) begin
                m_valid = 1;
                if (jmp_class == 0) begin
                    if (cond_mask == 7) begin
                        hit = 1; otag = "R3";
                    end else begin
                        hit = 0;
                        if (cond_mask[0] && m_flags[0]) hit = 1;
                        if (cond_mask[1] && m_flags[1]) hit = 1;
                        if (cond_mask[2] && m_flags[2]) hit = 1;
                        otag = "R2";
                    end
                    m_taken = hit;
                end else if (jmp_class == 1) begin
                    m_taken = 1; otag = "R8";
                end else begin
                    lm = longint'($signed(limit_in));
                    if (jmp_class == 2) begin
                        m_cnt = count_in - 32'd1;
                        nc = longint'($signed(m_cnt));
                        m_taken = (nc > lm); otag = "R6";
                    end else begin
                        m_cnt = count_in + 32'd1;
                        nc = longint'($signed(m_cnt));
                        m_taken = (nc <= lm); otag = "R7";
                    end
                    m_we = 1;
                end
                m_fetch = m_taken && indexed;
            end
            ftag = "R10";
            if (cmp_en) begin
                sa = longint'($signed(cmp_a));
                sb = longint'($signed(cmp_b));
                m_flags[0] = (sa < sb);
                m_flags[1] = (sa == sb);
                m_flags[2] = (sa > sb);
                ftag = "R4";
            end else if (flag_wr) begin
                m_flags = flag_in;
                ftag = "R5";
            end
        end
    end

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            chk(otag, "res_valid", res_valid, m_valid);
            chk(otag, "taken", taken, m_taken);
            chk(otag, "cnt_we", cnt_we, m_we);
            chk(otag, "cnt_out", cnt_out, m_cnt);
            chk(m_valid ? "R9" : otag, "fetch_indirect", fetch_indirect, m_fetch);
            chk(ftag, "flags", flags, m_flags);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle();
        flag_wr = 0; cmp_en = 0; jmp_valid = 0; indexed = 0;
    endtask

    task automatic set_flags(logic [3:0] f);
        @(negedge clk); idle(); flag_wr = 1; flag_in = f;
        @(negedge clk); idle();
    endtask

    task automatic do_cmp(logic [31:0] a, logic [31:0] b);
        @(negedge clk); idle(); cmp_en = 1; cmp_a = a; cmp_b = b;
        @(negedge clk); idle();
    endtask

    task automatic do_jmp(logic [1:0] c, logic [2:0] m, logic [31:0] cnt,
                          logic [31:0] lim, logic idx);
        @(negedge clk); idle();
        jmp_valid = 1; jmp_class = c; cond_mask = m;
        count_in = cnt; limit_in = lim; indexed = idx;
        @(negedge clk); idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 cleared flags: mask 7 still jumps (R3), others never (R2)
        for (int m = 0; m < 8; m++) do_jmp(2'd0, m[2:0], 0, 0, m[0]);
        // R2 / R5 each single flag pattern and mixes against every mask
        for (int f = 0; f < 16; f++) begin
            set_flags(f[3:0]);
            for (int m = 0; m < 8; m++) do_jmp(2'd0, m[2:0], 0, 0, f[1] ^ m[1]);
        end
        // R4 signed compares including overflow-prone pairs, carry kept
        set_flags(4'b1000);
        do_cmp(32'd5, 32'd3);
        do_cmp(32'd3, 32'd5);
        do_cmp(32'd7, 32'd7);
        do_cmp(32'h7FFF_FFFF, 32'h8000_0000);
        do_cmp(32'h8000_0000, 32'h7FFF_FFFF);
        do_cmp(32'h8000_0000, 32'd1);
        do_cmp(32'hFFFF_FFFF, 32'd0);
        set_flags(4'b0000);
        do_cmp(32'd0, 32'hFFFF_FFFF);
        // R5 compare wins over a same-cycle flag load
        @(negedge clk); idle();
        cmp_en = 1; cmp_a = 1; cmp_b = 2; flag_wr = 1; flag_in = 4'b1110;
        @(negedge clk); idle();
        // R10 branch tests the flags from before its own cycle's update
        set_flags(4'b0001);
        @(negedge clk); idle();
        jmp_valid = 1; jmp_class = 0; cond_mask = 3'b100; indexed = 1;
        cmp_en = 1; cmp_a = 9; cmp_b = 1;
        @(negedge clk); idle();
        do_jmp(2'd0, 3'b100, 0, 0, 1);
        // R6 index high, including signed wrap
        do_jmp(2'd2, 0, 32'd5, 32'd3, 1);
        do_jmp(2'd2, 0, 32'd4, 32'd3, 1);
        do_jmp(2'd2, 0, 32'h8000_0000, 32'd0, 0);
        do_jmp(2'd2, 0, 32'd0, 32'hFFFF_FFFE, 1);
        do_jmp(2'd2, 0, 32'd0, 32'hFFFF_FFFF, 1);
        // R7 index low-or-equal, including signed wrap
        do_jmp(2'd3, 0, 32'd2, 32'd3, 1);
        do_jmp(2'd3, 0, 32'd3, 32'd3, 1);
        do_jmp(2'd3, 0, 32'h7FFF_FFFF, 32'd0, 1);
        do_jmp(2'd3, 0, 32'hFFFF_FFFB, 32'hFFFF_FFFB, 0);
        // R8 / R9 subroutine jump, direct and indexed
        do_jmp(2'd1, 3'b000, 32'd77, 32'd1, 0);
        do_jmp(2'd1, 3'b000, 32'd77, 32'd1, 1);
        // back-to-back branches (R10)
        @(negedge clk); idle();
        jmp_valid = 1; jmp_class = 2; count_in = 10; limit_in = 0; indexed = 1;
        @(negedge clk);
        jmp_class = 3; count_in = 10; limit_in = 20;
        @(negedge clk); idle();
        // R1 reset again mid-run
        set_flags(4'b1111);
        @(negedge clk); rst = 1; jmp_valid = 1; jmp_class = 1;
        @(negedge clk); @(negedge clk); rst = 0; idle();
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule